// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the transfer datapath of one channel in a legacy-style DMA controller. It keeps an 8-bit page register, a 16-bit current address and a 16-bit current count, each loaded from the register interface. From these it forms a 24-bit physical address, which covers the low 16 MB. Every accepted transfer strobe moves the address up by one and the count down by one. A terminal-count pulse marks the transfer on which the count runs out.

A build-time parameter selects the unit of transfer. In byte mode the page register supplies address bits 23..16 and the offset supplies bits 15..0. In word mode the offset is shifted up one place, so it supplies bits 16..1. Page bit 0 is then dropped and address bit 0 is held low. The count always holds the number of transfers minus one. The offset wraps inside its 64K-unit window and never carries into the page, so software moves a transfer on to the next window by rewriting the page on its own. After terminal count the channel either reloads its start values, when the autoinitialize input is high, or masks itself until it is re-armed. Bus handshaking is left to the surrounding controller.

Top module: `chan_xfer_engine`

## Requirements
- R1: After a cycle with `rst` high, `masked` is 1, `tc` is 0, `residue` is 0x0000, `phys_addr` is 0 and `byte_en` is 2'b00.
- R2: With `WORD_MODE`=0, `phys_addr` equals {page, offset}: the page is on bits 23..16 and the offset on bits 15..0.
- R3: With `WORD_MODE`=1, `phys_addr` equals {page[7:1], offset, 1'b0}. Page bit 0 has no effect and bit 0 of `phys_addr` is always 0.
- R4: A clock edge with `xfer` high, `masked` low and `tc` low adds one to the offset and subtracts one from `residue`. `residue` always shows the current count.
- R5: The offset counts modulo 2^16. A step from 0xFFFF gives 0x0000 and leaves the page unchanged.
- R6: Loading count value N-1 gives exactly N transfers. `tc` is high for exactly one cycle, in the cycle after the transfer that takes the count from 0x0000 to 0xFFFF. A load of 0xFFFF gives 65536 transfers.
- R7: When `autoinit` is low at that transfer, `masked` becomes 1 together with `tc`. Later `xfer` strobes then change neither the offset nor the count until `arm` is pulsed.
- R8: When `autoinit` is high at that transfer, `masked` stays 0. In the `tc` cycle the offset and count reload from the values last loaded, and an `xfer` strobe in that cycle is ignored.
- R9: A write through `ld_page` changes only the page. The current offset and count keep their values.
- R10: `byte_en` is 2'b00 while masked. Otherwise it is 2'b11 in word mode. In byte mode it is 2'b01 for an even address and 2'b10 for an odd one.
- R11: A load strobe in the same cycle as an accepted transfer takes priority for the register it targets. The other register still steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_page | input | 1 | Write strobe for the page register |
| page_in | input | 8 | Page value |
| ld_addr | input | 1 | Write strobe for the base and current offset |
| addr_in | input | 16 | Offset value |
| ld_count | input | 1 | Write strobe for the base and current count |
| count_in | input | 16 | Count value (transfers minus one) |
| autoinit | input | 1 | Reload the start values at terminal count |
| arm | input | 1 | Clears the channel mask |
| xfer | input | 1 | Transfer strobe |
| phys_addr | output | 24 | Physical address of the current transfer |
| byte_en | output | 2 | Byte lane enables |
| tc | output | 1 | Terminal-count pulse |
| masked | output | 1 | Channel mask state |
| residue | output | 16 | Current count |

## Verification
On every cycle the assertions check four things. The offset and the count move in lockstep on each accepted strobe. Terminal count is a single-cycle pulse that comes with the mask when autoinitialize is off. A reload restores the stored base values. A page-only write leaves the count untouched. Only the bench scenarios can show the rest:
- the exact address bit mapping in each of the two modes,
- the offset wrap that leaves the page unchanged,
- the full run of 65536 transfers that ends in exactly one pulse,
- the load-versus-step priority.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

    localparam int OFS_W  = 16;
    localparam int PAGE_W = 8;
    localparam int PHYS_W = PAGE_W + OFS_W;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [PHYS_W-1:0] phys_t;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STEP   = 2'd2,
        OP_RELOAD = 2'd3
    } reg_op_e;

    typedef enum logic {
        XM_BYTE = 1'b0,
        XM_WORD = 1'b1
    } xfer_mode_e;

    function automatic phys_t form_phys(page_t pg, ofs_t ofs, xfer_mode_e m);
        phys_t r;
        if (m == XM_WORD)
            r = {pg[PAGE_W-1:1], ofs, 1'b0};
        else
            r = {pg, ofs};
        return r;
    endfunction

    function automatic logic [1:0] lane_sel(logic a0, logic off, xfer_mode_e m);
        logic [1:0] r;
        if (off)
            r = 2'b00;
        else if (m == XM_WORD)
            r = 2'b11;
        else
            r = a0 ? 2'b10 : 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/step_reg.sv
module step_reg
    import dmaeng_pkg::*;
#(
    parameter bit DOWN = 1'b0
) (
    input  logic    clk,
    input  logic    rst,
    input  reg_op_e op,
    input  ofs_t    load_val,
    output ofs_t    cur
);

    ofs_t base_q;
    ofs_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cur_q  <= '0;
        end else begin
            case (op)
                OP_LOAD: begin
                    base_q <= load_val;
                    cur_q  <= load_val;
                end
                OP_STEP: begin
                    if (DOWN)
                        cur_q <= cur_q - ofs_t'(1);
                    else
                        cur_q <= cur_q + ofs_t'(1);
                end
                OP_RELOAD: cur_q <= base_q;
                default:   cur_q <= cur_q;
            endcase
        end
    end

    assign cur = cur_q;

    // R8: a reload restores the stored start value
    a_r8_reload_base: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RELOAD) |=> (cur == $past(base_q)));

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import dmaeng_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    xfer,
    input  logic    arm,
    input  logic    ld_addr,
    input  logic    ld_count,
    input  logic    autoinit,
    input  logic    cnt_zero,
    output reg_op_e addr_op,
    output reg_op_e cnt_op,
    output logic    go,
    output logic    tc,
    output logic    masked
);

    logic tc_q;
    logic reload_q;
    logic mask_q;
    logic last_xfer;

    assign go        = xfer && !mask_q && !tc_q;
    assign last_xfer = go && cnt_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q     <= 1'b0;
            reload_q <= 1'b0;
            mask_q   <= 1'b1;
        end else begin
            tc_q     <= last_xfer;
            reload_q <= last_xfer && autoinit;
            if (last_xfer && !autoinit)
                mask_q <= 1'b1;
            else if (arm)
                mask_q <= 1'b0;
        end
    end

    always_comb begin
        if (ld_addr)       addr_op = OP_LOAD;
        else if (reload_q) addr_op = OP_RELOAD;
        else if (go)       addr_op = OP_STEP;
        else               addr_op = OP_HOLD;

        if (ld_count)      cnt_op = OP_LOAD;
        else if (reload_q) cnt_op = OP_RELOAD;
        else if (go)       cnt_op = OP_STEP;
        else               cnt_op = OP_HOLD;
    end

    assign tc     = tc_q;
    assign masked = mask_q;

    // R6: terminal count never lasts more than one cycle
    a_r6_tc_pulse: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);

    // R7: a final transfer without autoinit masks the channel with the pulse
    a_r7_mask_on_tc: assert property (@(posedge clk) disable iff (rst)
        (go && cnt_zero && !autoinit) |=> (tc && masked));

endmodule

// File: rtl/phys_map.sv
module phys_map
    import dmaeng_pkg::*;
#(
    parameter xfer_mode_e MODE = XM_BYTE
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ld_page,
    input  page_t      page_in,
    input  ofs_t       ofs,
    input  logic       masked,
    output phys_t      phys,
    output logic [1:0] lanes
);

    page_t page_q;

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= '0;
        else if (ld_page)
            page_q <= page_in;
    end

    always_comb begin
        phys  = form_phys(page_q, ofs, MODE);
        lanes = lane_sel(phys[0], masked, MODE);
    end

endmodule

// File: rtl/chan_xfer_engine.sv
module chan_xfer_engine
    import dmaeng_pkg::*;
#(
    parameter bit WORD_MODE = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_page,
    input  logic [7:0]  page_in,
    input  logic        ld_addr,
    input  logic [15:0] addr_in,
    input  logic        ld_count,
    input  logic [15:0] count_in,
    input  logic        autoinit,
    input  logic        arm,
    input  logic        xfer,
    output logic [23:0] phys_addr,
    output logic [1:0]  byte_en,
    output logic        tc,
    output logic        masked,
    output logic [15:0] residue
);

    localparam xfer_mode_e MODE = WORD_MODE ? XM_WORD : XM_BYTE;

    reg_op_e addr_op;
    reg_op_e cnt_op;
    logic    go;
    ofs_t    ofs_cur;
    ofs_t    cnt_cur;
    phys_t   phys;

    xfer_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .xfer     (xfer),
        .arm      (arm),
        .ld_addr  (ld_addr),
        .ld_count (ld_count),
        .autoinit (autoinit),
        .cnt_zero (cnt_cur == '0),
        .addr_op  (addr_op),
        .cnt_op   (cnt_op),
        .go       (go),
        .tc       (tc),
        .masked   (masked)
    );

    step_reg #(.DOWN(1'b0)) u_ofs (
        .clk      (clk),
        .rst      (rst),
        .op       (addr_op),
        .load_val (addr_in),
        .cur      (ofs_cur)
    );

    step_reg #(.DOWN(1'b1)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .op       (cnt_op),
        .load_val (count_in),
        .cur      (cnt_cur)
    );

    phys_map #(.MODE(MODE)) u_map (
        .clk     (clk),
        .rst     (rst),
        .ld_page (ld_page),
        .page_in (page_in),
        .ofs     (ofs_cur),
        .masked  (masked),
        .phys    (phys),
        .lanes   (byte_en)
    );

    assign phys_addr = phys;
    assign residue   = cnt_cur;

    // R4: offset and count move together by one on an accepted strobe
    a_r4_lockstep: assert property (@(posedge clk) disable iff (rst)
        (go && !ld_addr && !ld_count) |=>
            ((ofs_t'(ofs_cur - $past(ofs_cur)) == ofs_t'(1)) &&
             (ofs_t'($past(cnt_cur) - cnt_cur) == ofs_t'(1))));

    // R9: a page-only write leaves the count as it was
    a_r9_page_only: assert property (@(posedge clk) disable iff (rst)
        (ld_page && !ld_addr && !ld_count && !go && !tc) |=>
            (residue == $past(residue)));

    // R3: word mode never drives address bit 0
    a_r3_even_word: assert property (@(posedge clk) disable iff (rst)
        (MODE == XM_WORD) |-> (phys_addr[0] == 1'b0));

endmodule

// File: tb/chan_xfer_engine_tb.sv
module chan_xfer_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_page = 1'b0, ld_addr = 1'b0, ld_count = 1'b0;
    logic [7:0]  page_in = '0;
    logic [15:0] addr_in = '0, count_in = '0;
    logic        autoinit = 1'b0, arm = 1'b0, xfer = 1'b0;

    logic [23:0] pa_b, pa_w;
    logic [1:0]  be_b, be_w;
    logic        tc_b, tc_w, mk_b, mk_w;
    logic [15:0] rs_b, rs_w;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    chan_xfer_engine #(.WORD_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .ld_page(ld_page), .page_in(page_in),
        .ld_addr(ld_addr), .addr_in(addr_in), .ld_count(ld_count),
        .count_in(count_in), .autoinit(autoinit), .arm(arm), .xfer(xfer),
        .phys_addr(pa_b), .byte_en(be_b), .tc(tc_b), .masked(mk_b),
        .residue(rs_b)
    );

    chan_xfer_engine #(.WORD_MODE(1'b1)) u_dut_w (
        .clk(clk), .rst(rst), .ld_page(ld_page), .page_in(page_in),
        .ld_addr(ld_addr), .addr_in(addr_in), .ld_count(ld_count),
        .count_in(count_in), .autoinit(autoinit), .arm(arm), .xfer(xfer),
        .phys_addr(pa_w), .byte_en(be_w), .tc(tc_w), .masked(mk_w),
        .residue(rs_w)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_b(logic [7:0] pg, logic [15:0] a);
        return {pg, a};
    endfunction

    function automatic logic [23:0] exp_w(logic [7:0] pg, logic [15:0] a);
        return (24'(pg & 8'hFE) << 16) | (24'(a) << 1);
    endfunction

    task automatic setup(input logic [7:0] pg, input logic [15:0] a,
                         input logic [15:0] c, input logic ai);
        @(negedge clk);
        ld_page = 1'b1; page_in = pg;
        ld_addr = 1'b1; addr_in = a;
        ld_count = 1'b1; count_in = c;
        autoinit = ai; arm = 1'b1;
        @(negedge clk);
        ld_page = 1'b0; ld_addr = 1'b0; ld_count = 1'b0; arm = 1'b0;
    endtask

    task automatic pulse_xfer(input int n);
        xfer = 1'b1;
        repeat (n) @(negedge clk);
        xfer = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 masked", 32'(mk_b), 32'd1);
        chk("R1 tc", 32'(tc_b), 32'd0);
        chk("R1 residue", 32'(rs_w), 32'd0);
        chk("R1 phys", 32'(pa_b), 32'd0);
        chk("R1 byte_en", 32'(be_w), 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_map_and_step();
        setup(8'h35, 16'h1234, 16'd3, 1'b0);
        chk("R2 byte phys", 32'(pa_b), 32'(exp_b(8'h35, 16'h1234)));
        chk("R3 word phys", 32'(pa_w), 32'(exp_w(8'h35, 16'h1234)));
        chk("R10 byte even lanes", 32'(be_b), 32'h1);
        chk("R10 word lanes", 32'(be_w), 32'h3);
        pulse_xfer(1);
        chk("R4 offset up", 32'(pa_b), 32'(exp_b(8'h35, 16'h1235)));
        chk("R4 count down", 32'(rs_b), 32'd2);
        chk("R10 byte odd lanes", 32'(be_b), 32'h2);
        chk("R3 word phys step", 32'(pa_w), 32'(exp_w(8'h35, 16'h1235)));
        pulse_xfer(2);
        chk("R6 no tc early", 32'(tc_b), 32'd0);
        chk("R6 count at zero", 32'(rs_b), 32'd0);
        pulse_xfer(1);
        chk("R6 tc on last", 32'(tc_b), 32'd1);
        chk("R6 count underflow", 32'(rs_b), 32'hFFFF);
        chk("R7 masked with tc", 32'(mk_w), 32'd1);
        chk("R10 masked lanes", 32'(be_b), 32'h0);
        @(negedge clk);
        chk("R6 tc one cycle", 32'(tc_b), 32'd0);
        pulse_xfer(3);
        chk("R7 count frozen", 32'(rs_b), 32'hFFFF);
        chk("R7 offset frozen", 32'(pa_b), 32'(exp_b(8'h35, 16'h1238)));
    endtask

    task automatic t_wrap_and_page();
        setup(8'h10, 16'hFFFF, 16'd5, 1'b0);
        pulse_xfer(1);
        chk("R5 byte wrap", 32'(pa_b), 32'(exp_b(8'h10, 16'h0000)));
        chk("R5 word wrap", 32'(pa_w), 32'(exp_w(8'h10, 16'h0000)));
        @(negedge clk);
        ld_page = 1'b1; page_in = 8'h11;
        @(negedge clk);
        ld_page = 1'b0;
        chk("R9 count kept", 32'(rs_b), 32'd4);
        chk("R9 offset kept", 32'(pa_b), 32'(exp_b(8'h11, 16'h0000)));
        chk("R3 page bit0 ignored", 32'(pa_w), 32'(exp_w(8'h11, 16'h0000)));
    endtask

    task automatic t_autoinit();
        setup(8'h02, 16'h0100, 16'd1, 1'b1);
        xfer = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 tc", 32'(tc_b), 32'd1);
        chk("R8 still armed", 32'(mk_b), 32'd0);
        @(negedge clk);
        xfer = 1'b0;
        chk("R8 count reloaded", 32'(rs_b), 32'd1);
        chk("R8 offset reloaded", 32'(pa_b), 32'(exp_b(8'h02, 16'h0100)));
        chk("R8 word offset reloaded", 32'(pa_w), 32'(exp_w(8'h02, 16'h0100)));
        autoinit = 1'b0;
    endtask

    task automatic t_load_prio();
        setup(8'h00, 16'h0040, 16'd9, 1'b0);
        @(negedge clk);
        xfer = 1'b1; ld_count = 1'b1; count_in = 16'd7;
        @(negedge clk);
        xfer = 1'b0; ld_count = 1'b0;
        chk("R11 load wins", 32'(rs_b), 32'd7);
        chk("R11 offset stepped", 32'(pa_b), 32'(exp_b(8'h00, 16'h0041)));
    endtask

    task automatic t_full_run();
        int early = 0;
        setup(8'h07, 16'h0ABC, 16'hFFFF, 1'b0);
        xfer = 1'b1;
        for (int i = 0; i < 65536; i++) begin
            @(negedge clk);
            if (i < 65535 && tc_b) early++;
        end
        xfer = 1'b0;
        chk("R6 no early tc in full run", 32'(early), 32'd0);
        chk("R6 tc after 65536", 32'(tc_b), 32'd1);
        chk("R6 offset full circle", 32'(pa_b), 32'(exp_b(8'h07, 16'h0ABC)));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_map_and_step();
        t_wrap_and_page();
        t_autoinit();
        t_load_prio();
        t_full_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule